// File: doc/BRIEF.md
# Alarm-Capable 64-bit Tick Timer

This block keeps a 64-bit count that advances by one on every cycle in which an external tick-enable strobe is high. It sits behind a plain 32-bit register port with a select, a write flag, a byte address, write data and combinational read data. Software may reload the whole count, and it can read the count in two ways. One is a snapshot pair: reading the low word freezes the high word for the read that follows. The other is a raw pair that has no side effects.

Four compare alarms each watch the low 32 bits of the count. Writing an alarm's register sets its target and arms it. When the low word equals the target, the alarm fires once, sets a raw interrupt bit and disarms itself. The interrupt outputs are the raw bits masked by an enable register, ORed with a force register. The count can be frozen by a software freeze bit, or by either of two debug-halt inputs when the halt enable for that input is set.

Each alarm is a two-state machine. `ALM_IDLE` moves to `ALM_ARMED` on a write to the alarm register (the arm transition). `ALM_ARMED` returns to `ALM_IDLE` on a match (the fire transition) or on a 1 written to its bit of the armed register (the disarm transition). A write to the alarm register while it is already in `ALM_ARMED` keeps it armed with the new target. On every edge the counter takes one of three actions, in priority order: `CNT_LOAD` (commit a reload), `CNT_STEP` (advance by one), `CNT_HOLD` (keep the count).

Top module: `tick_timer64`

## Requirements
- R1: After reset the count, staged word, snapshot word, armed bits, freeze bit and all interrupt registers are 0. The halt-enable register reads 0x6 (bits 1 and 2 set), and `alarm_irq` is 0.
- R2: The count rises by exactly one on each clock edge where `tick_en` is 1 and no freeze applies, and it holds while `tick_en` is 0.
- R3: While bit 0 of the freeze register (0x30) is 1, the count does not change.
- R4: Bit 1 of the halt-enable register (0x2C) lets `dbg_halt[0]` freeze the count, and bit 2 lets `dbg_halt[1]` freeze it. A halt input whose enable bit is 0 has no effect.
- R5: A write to 0x04 only stages a low word, and the count is unchanged. A write to 0x00 loads the count with {written word, staged word} in one step.
- R6: A read of 0x0C returns the live low word and captures the live high word. A later read of 0x08 returns that captured word.
- R7: Reads of 0x24 (high) and 0x28 (low) return the live count and leave the captured high word unchanged.
- R8: A write to alarm register n (address 0x10 + 4n, n = 0..3) stores the target, which reads back at that address, and sets bit n of the armed register (0x20) on the next edge.
- R9: An armed alarm whose target equals the low count word sets its raw interrupt bit and clears its armed bit. This happens whether or not the count is ticking, and it fires only once per arming.
- R10: Writing a 1 to bit n of the armed register disarms alarm n, and a 0 bit has no effect.
- R11: Writing a 1 to bit n of the raw interrupt register (0x34) clears that bit, and a 0 leaves it unchanged. A firing alarm sets its bit even if a clear arrives in the same cycle.
- R12: The status register (0x40) and `alarm_irq` both equal (raw AND enable) OR force, where the enable register is at 0x38 and the force register is at 0x3C, with bit n for alarm n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count-advance strobe |
| dbg_halt | input | 2 | Debug-halt requests from two processors |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (7) | Byte address, word aligned |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data, combinational from the address |
| alarm_irq | output | NUM_ALARMS (4) | Masked-and-forced interrupt per alarm |

## Verification
The bench checks that a staged low write leaves the count alone until the high write commits it. A design that loads each half on its own write would show a torn value. It also checks that raw reads do not disturb the snapshot. A design that captures on any low read would return the wrong high word from 0x08. The bench arms an alarm whose target already equals the stopped count; a design that only compares on tick edges would never fire. It then reloads the count past the old target, where a design that forgets to disarm would fire a second time. It checks each halt input against its own enable bit, whether a 0 written to the raw or armed register clears anything, and whether force still drives the output when the enable mask is clear.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int OFF_LOADHI  = 'h00;
    localparam int OFF_LOADLO  = 'h04;
    localparam int OFF_SNAPHI  = 'h08;
    localparam int OFF_SNAPLO  = 'h0C;
    localparam int OFF_CMP0    = 'h10;
    localparam int OFF_ARMST   = 'h20;
    localparam int OFF_PEEKHI  = 'h24;
    localparam int OFF_PEEKLO  = 'h28;
    localparam int OFF_HALTEN  = 'h2C;
    localparam int OFF_FREEZE  = 'h30;
    localparam int OFF_IRQRAW  = 'h34;
    localparam int OFF_IRQMASK = 'h38;
    localparam int OFF_IRQFRC  = 'h3C;
    localparam int OFF_IRQSTAT = 'h40;

    typedef enum logic {
        ALM_IDLE  = 1'b0,
        ALM_ARMED = 1'b1
    } alm_state_e;

    typedef enum logic [1:0] {
        CNT_HOLD = 2'd0,
        CNT_STEP = 2'd1,
        CNT_LOAD = 2'd2
    } cnt_act_e;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int DW = 32,
    parameter int CW = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic          freeze,
    input  logic          ld_lo_we,
    input  logic          ld_hi_we,
    input  logic [DW-1:0] wdata,
    output logic [CW-1:0] cnt
);
    localparam int HW = CW - DW;

    cnt_act_e      act;
    logic [DW-1:0] stage_q;

    always_comb begin
        if (ld_hi_we)
            act = CNT_LOAD;
        else if (tick_en && !freeze)
            act = CNT_STEP;
        else
            act = CNT_HOLD;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            unique case (act)
                CNT_LOAD: cnt <= {wdata[HW-1:0], stage_q};
                CNT_STEP: cnt <= cnt + 1'b1;
                CNT_HOLD: cnt <= cnt;
                default:  cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            stage_q <= '0;
        else if (ld_lo_we)
            stage_q <= wdata;
    end

    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !freeze && !ld_hi_we) |=> cnt == $past(cnt) + 1'b1);

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((freeze || !tick_en) && !ld_hi_we) |=> cnt == $past(cnt));

    assert_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ld_hi_we |=> cnt[CW-1:DW] == $past(wdata[HW-1:0]));
endmodule

// File: rtl/tmr_alarm.sv
module tmr_alarm
    import tmr_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          arm_we,
    input  logic          disarm,
    input  logic [DW-1:0] wdata,
    input  logic [DW-1:0] cnt_lo,
    output logic          armed,
    output logic          fire,
    output logic [DW-1:0] target
);
    alm_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ALM_IDLE: begin
                if (arm_we) state_d = ALM_ARMED;
            end
            ALM_ARMED: begin
                if (arm_we)
                    state_d = ALM_ARMED;
                else if (disarm || cnt_lo == target)
                    state_d = ALM_IDLE;
            end
            default: state_d = ALM_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ALM_IDLE;
            target  <= '0;
        end else begin
            state_q <= state_d;
            if (arm_we) target <= wdata;
        end
    end

    always_comb begin
        armed = (state_q == ALM_ARMED);
        fire  = armed && (cnt_lo == target);
    end

    assert_arm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        arm_we |=> armed && target == $past(wdata));

    assert_single_shot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !arm_we) |=> !armed);

    assert_disarm_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (disarm && !arm_we) |=> !armed);
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] fire,
    input  logic         clr_we,
    input  logic         mask_we,
    input  logic         frc_we,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] raw,
    output logic [N-1:0] mask,
    output logic [N-1:0] frc,
    output logic [N-1:0] stat
);
    logic [N-1:0] clr_bits;

    always_comb begin
        clr_bits = clr_we ? wdata : '0;
        stat     = (raw & mask) | frc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw  <= '0;
            mask <= '0;
            frc  <= '0;
        end else begin
            raw <= (raw & ~clr_bits) | fire;
            if (mask_we) mask <= wdata;
            if (frc_we)  frc  <= wdata;
        end
    end

    assert_fire_sets_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (|fire) |=> (raw & $past(fire)) == $past(fire));

    assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && !(|fire)) |=> (raw & $past(wdata)) == '0);

    assert_force_R12: assert property (@(posedge clk) disable iff (!rst_n)
        frc_we |=> (stat & $past(wdata)) == $past(wdata));
endmodule

// File: rtl/tick_timer64.sv
module tick_timer64
    import tmr_pkg::*;
#(
    parameter int NUM_ALARMS = 4,
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 7
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_en,
    input  logic [1:0]            dbg_halt,
    input  logic                  bus_sel,
    input  logic                  bus_wr,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [DATA_W-1:0]     bus_wdata,
    output logic [DATA_W-1:0]     bus_rdata,
    output logic [NUM_ALARMS-1:0] alarm_irq
);
    localparam int CNT_W = 2 * DATA_W;
    localparam int AIW   = (NUM_ALARMS > 1) ? $clog2(NUM_ALARMS) : 1;
    localparam int CMP_END = OFF_CMP0 + 4 * NUM_ALARMS;

    logic                  wr_en, rd_en;
    logic                  alm_hit;
    logic [AIW-1:0]        alm_idx;
    logic [CNT_W-1:0]      cnt;
    logic [DATA_W-1:0]     snap_hi_q;
    logic [1:0]            halt_en_q;
    logic                  freeze_q;
    logic                  freeze;
    logic [NUM_ALARMS-1:0] armed, fire;
    logic [DATA_W-1:0]     tgt [NUM_ALARMS];
    logic [NUM_ALARMS-1:0] irq_raw, irq_mask, irq_frc, irq_stat;

    function automatic logic at(input logic [ADDR_W-1:0] a, input int off);
        return a == ADDR_W'(off);
    endfunction

    always_comb begin
        wr_en   = bus_sel && bus_wr;
        rd_en   = bus_sel && !bus_wr;
        alm_hit = (bus_addr >= ADDR_W'(OFF_CMP0)) && (bus_addr < ADDR_W'(CMP_END))
                  && (bus_addr[1:0] == 2'b00);
        alm_idx = AIW'((bus_addr - ADDR_W'(OFF_CMP0)) >> 2);
        freeze  = freeze_q || (halt_en_q[0] && dbg_halt[0])
                           || (halt_en_q[1] && dbg_halt[1]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_hi_q <= '0;
            halt_en_q <= 2'b11;
            freeze_q  <= 1'b0;
        end else begin
            if (rd_en && at(bus_addr, OFF_SNAPLO)) snap_hi_q <= cnt[CNT_W-1:DATA_W];
            if (wr_en && at(bus_addr, OFF_HALTEN)) halt_en_q <= bus_wdata[2:1];
            if (wr_en && at(bus_addr, OFF_FREEZE)) freeze_q  <= bus_wdata[0];
        end
    end

    tmr_counter #(.DW(DATA_W), .CW(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .freeze   (freeze),
        .ld_lo_we (wr_en && at(bus_addr, OFF_LOADLO)),
        .ld_hi_we (wr_en && at(bus_addr, OFF_LOADHI)),
        .wdata    (bus_wdata),
        .cnt      (cnt)
    );

    for (genvar i = 0; i < NUM_ALARMS; i++) begin : g_alm
        tmr_alarm #(.DW(DATA_W)) u_alm (
            .clk    (clk),
            .rst_n  (rst_n),
            .arm_we (wr_en && alm_hit && (alm_idx == AIW'(i))),
            .disarm (wr_en && at(bus_addr, OFF_ARMST) && bus_wdata[i]),
            .wdata  (bus_wdata),
            .cnt_lo (cnt[DATA_W-1:0]),
            .armed  (armed[i]),
            .fire   (fire[i]),
            .target (tgt[i])
        );
    end

    tmr_irq #(.N(NUM_ALARMS)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (fire),
        .clr_we  (wr_en && at(bus_addr, OFF_IRQRAW)),
        .mask_we (wr_en && at(bus_addr, OFF_IRQMASK)),
        .frc_we  (wr_en && at(bus_addr, OFF_IRQFRC)),
        .wdata   (bus_wdata[NUM_ALARMS-1:0]),
        .raw     (irq_raw),
        .mask    (irq_mask),
        .frc     (irq_frc),
        .stat    (irq_stat)
    );

    assign alarm_irq = irq_stat;

    always_comb begin
        bus_rdata = '0;
        if (alm_hit)
            bus_rdata = tgt[alm_idx];
        else if (at(bus_addr, OFF_SNAPHI))  bus_rdata = snap_hi_q;
        else if (at(bus_addr, OFF_SNAPLO))  bus_rdata = cnt[DATA_W-1:0];
        else if (at(bus_addr, OFF_ARMST))   bus_rdata = DATA_W'(armed);
        else if (at(bus_addr, OFF_PEEKHI))  bus_rdata = cnt[CNT_W-1:DATA_W];
        else if (at(bus_addr, OFF_PEEKLO))  bus_rdata = cnt[DATA_W-1:0];
        else if (at(bus_addr, OFF_HALTEN))  bus_rdata = DATA_W'({halt_en_q, 1'b0});
        else if (at(bus_addr, OFF_FREEZE))  bus_rdata = DATA_W'(freeze_q);
        else if (at(bus_addr, OFF_IRQRAW))  bus_rdata = DATA_W'(irq_raw);
        else if (at(bus_addr, OFF_IRQMASK)) bus_rdata = DATA_W'(irq_mask);
        else if (at(bus_addr, OFF_IRQFRC))  bus_rdata = DATA_W'(irq_frc);
        else if (at(bus_addr, OFF_IRQSTAT)) bus_rdata = DATA_W'(irq_stat);
    end

    assert_snapshot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && at(bus_addr, OFF_SNAPLO)) |=> snap_hi_q == $past(cnt[CNT_W-1:DATA_W]));

    assert_peek_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (at(bus_addr, OFF_PEEKHI) || at(bus_addr, OFF_PEEKLO))) |=> $stable(snap_hi_q));

    assert_halt_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_en_q[0] && dbg_halt[0] && !(wr_en && at(bus_addr, OFF_LOADHI))) |=> $stable(cnt));
endmodule

// File: tb/tick_timer64_test.sv
module tick_timer64_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [1:0]  dbg_halt = 2'b00;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [3:0]  alarm_irq;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    tick_timer64 uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .dbg_halt(dbg_halt),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .alarm_irq(alarm_irq)
    );

    // vector: {write, addr[6:0], data[31:0], expected[31:0], req[3:0]}
    localparam int NV = 26;
    localparam logic [75:0] VEC [NV] = '{
        {1'b0, 7'h2C, 32'h0,        32'h6,        4'd1},  // R1 halt enables
        {1'b0, 7'h30, 32'h0,        32'h0,        4'd1},  // R1 freeze
        {1'b0, 7'h20, 32'h0,        32'h0,        4'd1},  // R1 armed
        {1'b0, 7'h34, 32'h0,        32'h0,        4'd1},  // R1 raw irq
        {1'b0, 7'h28, 32'h0,        32'h0,        4'd1},  // R1 count
        {1'b1, 7'h04, 32'h11110000, 32'h0,        4'd5},  // R5 stage
        {1'b0, 7'h28, 32'h0,        32'h0,        4'd5},  // R5 not yet loaded
        {1'b1, 7'h00, 32'h000000AB, 32'h0,        4'd5},  // R5 commit
        {1'b0, 7'h28, 32'h0,        32'h11110000, 4'd5},
        {1'b0, 7'h24, 32'h0,        32'h000000AB, 4'd5},
        {1'b0, 7'h08, 32'h0,        32'h0,        4'd7},  // R7 raw reads no capture
        {1'b0, 7'h0C, 32'h0,        32'h11110000, 4'd6},  // R6 snapshot low
        {1'b0, 7'h08, 32'h0,        32'h000000AB, 4'd6},  // R6 captured high
        {1'b1, 7'h10, 32'h00005555, 32'h0,        4'd8},  // R8 arm alarm0
        {1'b0, 7'h10, 32'h0,        32'h00005555, 4'd8},
        {1'b0, 7'h20, 32'h0,        32'h1,        4'd8},
        {1'b1, 7'h20, 32'h0,        32'h0,        4'd10}, // R10 zero ignored
        {1'b0, 7'h20, 32'h0,        32'h1,        4'd10},
        {1'b1, 7'h20, 32'h1,        32'h0,        4'd10}, // R10 disarm
        {1'b0, 7'h20, 32'h0,        32'h0,        4'd10},
        {1'b1, 7'h3C, 32'h4,        32'h0,        4'd12}, // R12 force
        {1'b0, 7'h40, 32'h0,        32'h4,        4'd12},
        {1'b1, 7'h38, 32'hF,        32'h0,        4'd12},
        {1'b0, 7'h40, 32'h0,        32'h4,        4'd12},
        {1'b1, 7'h3C, 32'h0,        32'h0,        4'd12},
        {1'b0, 7'h40, 32'h0,        32'h0,        4'd12}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // called at a negedge, returns at the next negedge
    task automatic bus_write(input logic [6:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [6:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic run_ticks(input int n);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 irq out", 32'(alarm_irq), 32'h0);

        for (int k = 0; k < NV; k++) begin
            logic [75:0] v;
            v = VEC[k];
            if (v[75]) bus_write(v[74:68], v[67:36]);
            else begin
                bus_read(v[74:68], rd);
                chk($sformatf("R%0d vec %0d", v[3:0], k), rd, v[35:4]);
            end
        end

        // R2 counting and holding
        bus_write(7'h04, 32'h100);
        bus_write(7'h00, 32'h0);
        run_ticks(10);
        bus_read(7'h28, rd); chk("R2 step", rd, 32'h10A);
        repeat (5) @(negedge clk);
        bus_read(7'h28, rd); chk("R2 hold", rd, 32'h10A);

        // R3 software freeze
        bus_write(7'h30, 32'h1);
        run_ticks(10);
        bus_read(7'h28, rd); chk("R3 freeze", rd, 32'h10A);
        bus_write(7'h30, 32'h0);

        // R4 debug halt gating
        dbg_halt = 2'b01;
        run_ticks(10);
        bus_read(7'h28, rd); chk("R4 halt0 enabled", rd, 32'h10A);
        bus_write(7'h2C, 32'h4);
        run_ticks(10);
        bus_read(7'h28, rd); chk("R4 halt0 disabled", rd, 32'h114);
        dbg_halt = 2'b10;
        run_ticks(10);
        bus_read(7'h28, rd); chk("R4 halt1 enabled", rd, 32'h114);
        dbg_halt = 2'b00;
        bus_write(7'h2C, 32'h6);

        // R9 alarm fire while ticking
        bus_write(7'h04, 32'h0);
        bus_write(7'h00, 32'h0);
        bus_write(7'h14, 32'd20);
        run_ticks(30);
        bus_read(7'h34, rd); chk("R9 raw set", rd, 32'h2);
        bus_read(7'h20, rd); chk("R9 disarmed", rd, 32'h0);
        chk("R12 irq out", 32'(alarm_irq), 32'h2);
        bus_read(7'h28, rd); chk("R2 count 30", rd, 32'd30);

        // R11 clear semantics
        bus_write(7'h34, 32'h0);
        bus_read(7'h34, rd); chk("R11 zero ignored", rd, 32'h2);
        bus_write(7'h34, 32'h2);
        bus_read(7'h34, rd); chk("R11 cleared", rd, 32'h0);
        chk("R11 irq out low", 32'(alarm_irq), 32'h0);

        // R9 fires only once per arming
        bus_write(7'h04, 32'h0);
        bus_write(7'h00, 32'h0);
        run_ticks(30);
        bus_read(7'h34, rd); chk("R9 single shot", rd, 32'h0);

        // R9 match on a stopped count
        bus_write(7'h1C, 32'd30);
        @(negedge clk);
        bus_read(7'h34, rd); chk("R9 idle match", rd, 32'h8);
        bus_read(7'h20, rd); chk("R9 idle disarm", rd, 32'h0);

        // R12 mask gating
        bus_write(7'h38, 32'h0);
        chk("R12 masked out", 32'(alarm_irq), 32'h0);
        bus_read(7'h40, rd); chk("R12 status masked", rd, 32'h0);
        bus_write(7'h38, 32'h8);
        chk("R12 unmasked", 32'(alarm_irq), 32'h8);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule